// File: doc/BRIEF.md
# Shift and Rotate Unit with Condition Flags

This block is a purely combinational shifter for an integer datapath. In one evaluation it applies one of seven shift or rotate operations to an operand of 1, 2, 4 or 8 bytes. It produces the new destination value and an updated flag word. It holds no state, so there are no states or transitions to name: every output follows its inputs within the same cycle.

The caller supplies the old destination value, so narrow results can be merged into a wide register. It also supplies the current flag word and an update mask that limits which flags may change. The carry, extended carry and overflow flags follow a separate rule for each operation. The through-carry rotates move the incoming carry into the operand ring. Zero, sign and parity are derived from the sized result by a shared helper. When the effective count is zero, the flag word does not change.

Top module: `shrot_unit`

## Requirements
- R1: The count is cut to its low 6 bits when the size code is 3 (8 bytes). For size codes 0, 1 and 2 (1, 2 and 4 bytes) it is cut to its low 5 bits. Every later rule uses this effective count n and the operand width W (8, 16, 32 or 64 bits).
- R2: When n is 0, the flag word passes through unchanged. Rotate opcodes 3 to 6 return the old destination unchanged. Shift opcodes 0 to 2 write the source into the low W bits.
- R3: The managed flags are carry (bit 0), parity (bit 2), zero (bit 6), sign (bit 7), overflow (bit 11) and extended carry (bit 13). A managed flag changes only if its bit is set in the update mask. All other bits of the flag word never change.
- R4: For sizes below 8 bytes, result bits W and above equal the old destination.
- R5: Opcode 0 shifts left and fills with zeros. Carry is the last bit shifted out, which is source bit W−n and is 0 once n exceeds W. Overflow is that carry XOR the top bit of the result.
- R6: Opcode 1 shifts right and fills with zeros. Carry is source bit n−1, or 0 once n exceeds W. Overflow equals the top bit of the source.
- R7: Opcode 2 shifts right and fills with copies of the source sign bit. Carry is source bit n−1, or the sign bit once n exceeds W. Overflow is always written as 0.
- R8: Opcode 3 rotates right by n mod W. Carry is the top bit of the result. Overflow is the XOR of the result's two highest bits.
- R9: Opcode 4 rotates left by n mod W. Carry is bit 0 of the result. Overflow is the result's top bit XOR its bit 0.
- R10: Opcode 5 rotates right through a (W+1)-bit ring made of the carry input above the source, by n mod (W+1). The new carry is the bit that ends in the ring's top position. Overflow is the carry input XOR the source top bit.
- R11: Opcode 6 rotates left through the same ring by n mod (W+1). The new carry is the ring's top bit afterwards. Overflow is the result's top bit XOR the new carry.
- R12: Zero is set when the W-bit result is all zeros. Sign is the result's bit W−1. Parity is set when the low 8 result bits hold an even number of ones. Extended carry always takes the same value as carry.
- R13: Opcode 7 is not an operation: the result is the old destination and the flag word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code, 0 to 7 |
| size_i | input | 2 | Operand size code: 0=1 byte, 1=2, 2=4, 3=8 |
| dst_old_i | input | 64 | Previous destination value |
| src_i | input | 64 | Operand to shift or rotate |
| count_i | input | 6 | Raw shift count |
| carry_i | input | 1 | Incoming carry for the through-carry rotates |
| flags_i | input | 16 | Current flag word |
| upd_mask_i | input | 16 | Per-flag update enable |
| result_o | output | 64 | New destination value |
| flags_o | output | 16 | New flag word |

## Verification
Every opcode is run at every size with counts of 0, 1, W−1 and W, and with random counts.
- Count 0 shows that flags are held and rotates keep the destination.
- Count 1 and count W−1 pin down the carry bit index at both ends of the operand.
- A count equal to W separates a zero-filling shift from an arithmetic one, and a plain rotate from a ring rotate.
- Counts of 32 and above on narrow sizes check the 5-bit cut. Ring counts above W check the modulo-(W+1) wrap.
- Both carry-input values are used. Random masks and random flag words show that only enabled managed bits move.
- A result that becomes zero, and operands with known parity, check the zero and parity flags.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic [2:0] {
        OP_SHL = 3'd0,
        OP_SHR = 3'd1,
        OP_SAR = 3'd2,
        OP_ROR = 3'd3,
        OP_ROL = 3'd4,
        OP_RCR = 3'd5,
        OP_RCL = 3'd6,
        OP_NOP = 3'd7
    } sr_op_e;

    localparam int FLAG_W    = 16;
    localparam int FB_CARRY  = 0;
    localparam int FB_PARITY = 2;
    localparam int FB_ZERO   = 6;
    localparam int FB_SIGN   = 7;
    localparam int FB_OVF    = 11;
    localparam int FB_XCARRY = 13;

    localparam logic [FLAG_W-1:0] FLAG_MANAGED =
        FLAG_W'((1 << FB_CARRY) | (1 << FB_PARITY) | (1 << FB_ZERO) |
                (1 << FB_SIGN)  | (1 << FB_OVF)    | (1 << FB_XCARRY));

    function automatic logic is_rotate(input sr_op_e op);
        return (op == OP_ROR) || (op == OP_ROL) ||
               (op == OP_RCR) || (op == OP_RCL);
    endfunction

endpackage

// File: rtl/shrot_zsp.sv
module shrot_zsp #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    output logic         zero,
    output logic         sign,
    output logic         parity
);
    assign zero   = (val == '0);
    assign sign   = val[W-1];
    assign parity = ~^val[7:0];
endmodule

// File: rtl/shrot_lane.sv
module shrot_lane
    import shrot_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 6
) (
    input  sr_op_e              op,
    input  logic [W-1:0]        src,
    input  logic [CNT_W-1:0]    cnt,
    input  logic                carry_in,
    output logic [W-1:0]        res,
    output logic [FLAG_W-1:0]   calc
);
    localparam int LW   = $clog2(W);
    localparam int RING = W + 1;

    function automatic logic [CNT_W-1:0] ring_mod(input logic [CNT_W-1:0] c);
        int r;
        r = int'(c);
        for (int i = 0; i < 4; i++) begin
            if (r >= RING) r = r - RING;
        end
        return CNT_W'(r);
    endfunction

    logic [W:0]         shl_t;
    logic [W:0]         shr_t;
    logic [W:0]         sar_t;
    logic [W-1:0]       ror_r;
    logic [W-1:0]       rol_r;
    logic [W:0]         ring;
    logic [W:0]         rcr_r;
    logic [W:0]         rcl_r;
    logic [LW-1:0]      rot_amt;
    logic [CNT_W-1:0]   ring_amt;
    logic               cf;
    logic               of;
    logic               zf;
    logic               sf;
    logic               pf;

    assign rot_amt  = cnt[LW-1:0];
    assign ring_amt = ring_mod(cnt);
    assign ring     = {carry_in, src};

    assign shl_t = {1'b0, src} << cnt;
    assign shr_t = {src, 1'b0} >> cnt;
    assign sar_t = $signed({src, 1'b0}) >>> cnt;
    assign ror_r = (src >> rot_amt) | (src << (W - int'(rot_amt)));
    assign rol_r = (src << rot_amt) | (src >> (W - int'(rot_amt)));
    assign rcr_r = (ring >> ring_amt) | (ring << (RING - int'(ring_amt)));
    assign rcl_r = (ring << ring_amt) | (ring >> (RING - int'(ring_amt)));

    always_comb begin
        res = src;
        cf  = 1'b0;
        of  = 1'b0;
        unique case (op)
            OP_SHL: begin
                res = shl_t[W-1:0];
                cf  = shl_t[W];
                of  = shl_t[W] ^ shl_t[W-1];
            end
            OP_SHR: begin
                res = shr_t[W:1];
                cf  = shr_t[0];
                of  = src[W-1];
            end
            OP_SAR: begin
                res = sar_t[W:1];
                cf  = sar_t[0];
                of  = 1'b0;
            end
            OP_ROR: begin
                res = ror_r;
                cf  = ror_r[W-1];
                of  = ror_r[W-1] ^ ror_r[W-2];
            end
            OP_ROL: begin
                res = rol_r;
                cf  = rol_r[0];
                of  = rol_r[W-1] ^ rol_r[0];
            end
            OP_RCR: begin
                res = rcr_r[W-1:0];
                cf  = rcr_r[W];
                of  = carry_in ^ src[W-1];
            end
            OP_RCL: begin
                res = rcl_r[W-1:0];
                cf  = rcl_r[W];
                of  = rcl_r[W-1] ^ rcl_r[W];
            end
            default: begin
                res = src;
                cf  = 1'b0;
                of  = 1'b0;
            end
        endcase
    end

    shrot_zsp #(.W(W)) u_zsp (
        .val    (res),
        .zero   (zf),
        .sign   (sf),
        .parity (pf)
    );

    always_comb begin
        calc            = '0;
        calc[FB_CARRY]  = cf;
        calc[FB_XCARRY] = cf;
        calc[FB_OVF]    = of;
        calc[FB_ZERO]   = zf;
        calc[FB_SIGN]   = sf;
        calc[FB_PARITY] = pf;
    end

    always_comb begin
        if (op == OP_SAR && cnt != '0) begin
            assert_sar_sign_fill_R7: assert (res[W-1] == src[W-1]);
        end
        if (op == OP_ROR || op == OP_ROL) begin
            assert_rotate_keeps_ones_R8: assert ($countones(res) == $countones(src));
        end
        if (op == OP_SHL && cnt == CNT_W'(1)) begin
            assert_shl_one_carry_R5: assert (calc[FB_CARRY] == src[W-1]);
        end
    end
endmodule

// File: rtl/shrot_flag_merge.sv
module shrot_flag_merge
    import shrot_pkg::*;
(
    input  logic [FLAG_W-1:0] flags_in,
    input  logic [FLAG_W-1:0] mask,
    input  logic [FLAG_W-1:0] calc,
    input  logic              enable,
    output logic [FLAG_W-1:0] flags_out
);
    logic [FLAG_W-1:0] sel;

    assign sel       = mask & FLAG_MANAGED;
    assign flags_out = enable ? ((flags_in & ~sel) | (calc & sel)) : flags_in;
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CW     = $clog2(DATA_W)
) (
    input  logic [2:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] dst_old_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [CW-1:0]     count_i,
    input  logic              carry_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [FLAG_W-1:0] upd_mask_i,
    output logic [DATA_W-1:0] result_o,
    output logic [FLAG_W-1:0] flags_o
);
    localparam int NSZ = 4;

    sr_op_e              op_e;
    logic [CW-1:0]       cnt_m;
    logic                cnt_zero;
    logic                keep_dst;
    logic                flag_en;
    logic [DATA_W-1:0]   merged [NSZ];
    logic [FLAG_W-1:0]   calc_arr [NSZ];
    logic [DATA_W-1:0]   sel_res;
    logic [FLAG_W-1:0]   sel_calc;

    assign op_e     = sr_op_e'(op_i);
    assign cnt_m    = (size_i == 2'd3) ? count_i : {1'b0, count_i[CW-2:0]};
    assign cnt_zero = (cnt_m == '0);
    assign keep_dst = (op_e == OP_NOP) || (cnt_zero && is_rotate(op_e));
    assign flag_en  = !cnt_zero && (op_e != OP_NOP);

    for (genvar s = 0; s < NSZ; s++) begin : g_size
        localparam int W = DATA_W >> (NSZ - 1 - s);
        logic [W-1:0]      lres;
        logic [FLAG_W-1:0] lcalc;

        shrot_lane #(.W(W), .CNT_W(CW)) u_lane (
            .op       (op_e),
            .src      (src_i[W-1:0]),
            .cnt      (cnt_m),
            .carry_in (carry_i),
            .res      (lres),
            .calc     (lcalc)
        );

        assign calc_arr[s] = lcalc;
        if (W < DATA_W) begin : g_narrow
            assign merged[s] = {dst_old_i[DATA_W-1:W], lres};
            always_comb begin
                if (size_i == 2'(s)) begin
                    assert_upper_bits_kept_R4: assert (result_o[DATA_W-1:W] == dst_old_i[DATA_W-1:W]);
                end
            end
        end else begin : g_full
            assign merged[s] = lres;
        end
    end

    assign sel_res  = merged[size_i];
    assign sel_calc = calc_arr[size_i];
    assign result_o = keep_dst ? dst_old_i : sel_res;

    shrot_flag_merge u_merge (
        .flags_in  (flags_i),
        .mask      (upd_mask_i),
        .calc      (sel_calc),
        .enable    (flag_en),
        .flags_out (flags_o)
    );

    always_comb begin
        if (cnt_zero) begin
            assert_zero_count_holds_flags_R2: assert (flags_o == flags_i);
        end
        assert_unmasked_flags_hold_R3: assert (((flags_o ^ flags_i) & ~(upd_mask_i & FLAG_MANAGED)) == '0);
        if (op_e == OP_NOP) begin
            assert_nop_keeps_dst_R13: assert (result_o == dst_old_i);
        end
    end
endmodule

// File: tb/test_shrot_unit.sv
module test_shrot_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op;
    logic [1:0]  size;
    logic [63:0] dst_old;
    logic [63:0] src;
    logic [5:0]  count;
    logic        carry;
    logic [15:0] flags_in;
    logic [15:0] upd_mask;
    logic [63:0] result;
    logic [15:0] flags_out;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    localparam int P_CF = 0, P_PF = 2, P_ZF = 6, P_SF = 7, P_OF = 11, P_XC = 13;

    always #4 clk = ~clk;

    shrot_unit i_shrot_unit (
        .op_i       (op),
        .size_i     (size),
        .dst_old_i  (dst_old),
        .src_i      (src),
        .count_i    (count),
        .carry_i    (carry),
        .flags_i    (flags_in),
        .upd_mask_i (upd_mask),
        .result_o   (result),
        .flags_o    (flags_out)
    );

    function automatic void model(input logic [2:0] o, input logic [1:0] sz,
                                  input logic [63:0] d, input logic [63:0] s,
                                  input logic [5:0] c, input logic ci,
                                  input logic [15:0] fi, input logic [15:0] fm,
                                  output logic [63:0] r, output logic [15:0] fo);
        int          w;
        int          n;
        logic [63:0] mw;
        logic [63:0] v;
        logic        cy;
        logic        b;
        logic        cf;
        logic        of;
        w  = 8 << sz;
        mw = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
        n  = (sz == 2'd3) ? int'(c) : int'(c & 6'd31);
        v  = s & mw;
        cy = ci;
        fo = fi;
        if (o == 3'd7) begin
            r = d;
            return;
        end
        if (n == 0) begin
            r = (o >= 3'd3) ? d : ((d & ~mw) | v);
            return;
        end
        for (int i = 0; i < n; i++) begin
            case (o)
                3'd0: begin cy = v[w-1]; v = (v << 1) & mw; end
                3'd1: begin cy = v[0]; v = v >> 1; end
                3'd2: begin cy = v[0]; b = v[w-1]; v = (v >> 1) | (64'(b) << (w-1)); end
                3'd3: begin b = v[0]; v = (v >> 1) | (64'(b) << (w-1)); end
                3'd4: begin b = v[w-1]; v = ((v << 1) & mw) | 64'(b); end
                3'd5: begin b = v[0]; v = (v >> 1) | (64'(cy) << (w-1)); cy = b; end
                default: begin b = v[w-1]; v = ((v << 1) & mw) | 64'(cy); cy = b; end
            endcase
        end
        case (o)
            3'd0: begin cf = cy; of = cy ^ v[w-1]; end
            3'd1: begin cf = cy; of = s[w-1]; end
            3'd2: begin cf = cy; of = 1'b0; end
            3'd3: begin cf = v[w-1]; of = v[w-1] ^ v[w-2]; end
            3'd4: begin cf = v[0]; of = v[w-1] ^ v[0]; end
            3'd5: begin cf = cy; of = ci ^ s[w-1]; end
            default: begin cf = cy; of = v[w-1] ^ cy; end
        endcase
        if (fm[P_CF]) fo[P_CF] = cf;
        if (fm[P_XC]) fo[P_XC] = cf;
        if (fm[P_OF]) fo[P_OF] = of;
        if (fm[P_ZF]) fo[P_ZF] = (v == 64'd0);
        if (fm[P_SF]) fo[P_SF] = v[w-1];
        if (fm[P_PF]) fo[P_PF] = ~^v[7:0];
        r = (d & ~mw) | v;
    endfunction

    task automatic apply(input string req, input logic [2:0] o, input logic [1:0] sz,
                         input logic [63:0] d, input logic [63:0] s, input logic [5:0] c,
                         input logic ci, input logic [15:0] fi, input logic [15:0] fm);
        logic [63:0] er;
        logic [15:0] ef;
        @(negedge clk);
        op = o; size = sz; dst_old = d; src = s; count = c;
        carry = ci; flags_in = fi; upd_mask = fm;
        #2;
        model(o, sz, d, s, c, ci, fi, fm, er, ef);
        n_vec++;
        if (result !== er || flags_out !== ef) begin
            n_fail++;
            $display("FAIL %s op=%0d size=%0d cnt=%0d: result %h flags %h, expected %h flags %h",
                     req, o, sz, c, result, flags_out, er, ef);
        end
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    task automatic sweep_op(input string req, input logic [2:0] o);
        for (int sz = 0; sz < 4; sz++) begin
            int w = 8 << sz;
            for (int k = 0; k < 7; k++) begin
                logic [5:0] c;
                case (k)
                    0: c = 6'd0;
                    1: c = 6'd1;
                    2: c = 6'(w - 1);
                    3: c = 6'(w % 64);
                    default: c = 6'($urandom);
                endcase
                apply(req, o, 2'(sz), rnd64(), rnd64(), c, 1'($urandom),
                      16'($urandom), 16'hFFFF);
            end
        end
    endtask

    task automatic t_idle();
        apply("R2", 3'd0, 2'd0, 64'd0, 64'd0, 6'd0, 1'b0, 16'd0, 16'd0);
    endtask

    task automatic t_count_cut();
        apply("R1", 3'd0, 2'd0, rnd64(), 64'h81, 6'd35, 1'b0, 16'h0, 16'hFFFF);
        apply("R1", 3'd3, 2'd1, rnd64(), rnd64(), 6'd32, 1'b1, 16'h5A5A, 16'hFFFF);
        apply("R1", 3'd1, 2'd3, rnd64(), rnd64(), 6'd33, 1'b0, 16'h0, 16'hFFFF);
        apply("R1", 3'd2, 2'd2, rnd64(), 64'h8000_0000, 6'd63, 1'b0, 16'h0, 16'hFFFF);
    endtask

    task automatic t_zero_count();
        for (int o = 0; o < 7; o++)
            apply("R2", 3'(o), 2'($urandom), rnd64(), rnd64(), 6'd0, 1'b1,
                  16'($urandom), 16'hFFFF);
    endtask

    task automatic t_mask();
        for (int i = 0; i < 24; i++)
            apply("R3", 3'($urandom % 7), 2'($urandom), rnd64(), rnd64(),
                  6'($urandom), 1'($urandom), 16'($urandom), 16'($urandom));
    endtask

    task automatic t_upper();
        for (int sz = 0; sz < 3; sz++)
            apply("R4", 3'd0, 2'(sz), 64'hDEAD_BEEF_CAFE_F00D, 64'hFFFF_FFFF_FFFF_FFFF,
                  6'd3, 1'b0, 16'h0, 16'hFFFF);
    endtask

    task automatic t_flags();
        apply("R12", 3'd0, 2'd0, 64'd0, 64'h80, 6'd1, 1'b0, 16'h0, 16'hFFFF);
        apply("R12", 3'd1, 2'd1, 64'd0, 64'h0306, 6'd1, 1'b0, 16'hFFFF, 16'hFFFF);
        apply("R12", 3'd4, 2'd2, 64'd0, 64'h4000_0001, 6'd1, 1'b0, 16'h0, 16'hFFFF);
    endtask

    task automatic t_ring_wrap();
        apply("R10", 3'd5, 2'd0, rnd64(), 64'hA5, 6'd9, 1'b1, 16'h0, 16'hFFFF);
        apply("R10", 3'd5, 2'd0, rnd64(), 64'h3C, 6'd31, 1'b0, 16'h0, 16'hFFFF);
        apply("R11", 3'd6, 2'd1, rnd64(), 64'h8001, 6'd17, 1'b1, 16'h0, 16'hFFFF);
        apply("R11", 3'd6, 2'd0, rnd64(), 64'h81, 6'd8, 1'b0, 16'h0, 16'hFFFF);
    endtask

    task automatic t_nop();
        for (int i = 0; i < 4; i++)
            apply("R13", 3'd7, 2'(i), rnd64(), rnd64(), 6'($urandom | 1), 1'b1,
                  16'($urandom), 16'hFFFF);
    endtask

    initial begin
        op = 3'd0; size = 2'd0; dst_old = '0; src = '0; count = '0;
        carry = 1'b0; flags_in = '0; upd_mask = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_count_cut();
        t_zero_count();
        sweep_op("R5", 3'd0);
        sweep_op("R6", 3'd1);
        sweep_op("R7", 3'd2);
        sweep_op("R8", 3'd3);
        sweep_op("R9", 3'd4);
        sweep_op("R10", 3'd5);
        sweep_op("R11", 3'd6);
        t_ring_wrap();
        t_mask();
        t_upper();
        t_flags();
        t_nop();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule